// File: doc/BRIEF.md
# Escalating Watchdog Timer Bank

This block holds a parameterized set of independent watchdog timers that share one core-clock prescaler. Each watchdog keeps a small configuration/status word made up of an enable mode, an escalation stage, a reload length and a live down-count. While a watchdog is armed, its count drops by one on every prescaler tick. When the count runs out, the watchdog moves up one stage. The first stage raises a first interrupt, the second stage raises a second interrupt, and the third stage asserts a reset request. How far a watchdog may escalate is set by its mode.

Software keeps a watchdog quiet by poking it. A poke reloads the count from the length and returns the stage to idle. Writing the configuration word arms, re-arms or disables a watchdog. Every watchdog's word can be read back through a combinational read port. Each watchdog has two stop enables, one for a debug-halt input and one for a global-halt input, that freeze its count while the matching input is high.

Top module: `wdog_bank`

## Requirements
- R1: After reset, every watchdog's word reads as zero and all irq_first, irq_second and rst_req outputs are low.
- R2: The word is laid out as follows: mode in bits [1:0], stage in [3:2], length in [4 +: LEN_W], count immediately above the length (CNT_W bits), then a debug-stop enable bit, then a global-stop enable bit. With the defaults these are [19:4], [43:20], 44 and 45. A write stores mode, length and both stop enables, clears the stage to 0 and loads the count with length << (CNT_W-LEN_W). The stage and count bits of the written word are ignored.
- R3: While the stage is below the mode and the watchdog is not frozen, the count falls by exactly one every 2^TICK_LOG2 clocks.
- R4: A tick that would bring the count to zero is an expiry. The stage rises by one and the count reloads from the length. Consecutive expiries are exactly length × 2^(CNT_W-LEN_W+TICK_LOG2) clocks apart. With length 0, the first tick expires the watchdog.
- R5: Reaching stage 1 pulses irq_first for one cycle, and reaching stage 2 pulses irq_second for one cycle. Reaching stage 3 raises rst_req, which stays high until rst_n.
- R6: The stage never exceeds the mode (mode 1 stops at the first interrupt, mode 2 at the second, mode 3 at reset). Once the stage equals the mode, the count holds.
- R7: A poke reloads the count from the length and clears the stage to 0. Regular pokes spaced closer than one period prevent any expiry.
- R8: The count is frozen while (debug-stop enable AND dbg_stop) OR (global-stop enable AND glb_stop). A halt input whose enable is clear has no effect.
- R9: Writing an all-zero word disables the watchdog. Mode 0 never counts or expires, and the word reads back as zero.
- R10: Writes and pokes to an index of N_WDT or above change nothing. A read of such an index returns zero. Watchdogs are independent of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | IDX_W | Watchdog selected by the write |
| wr_data | input | 64 | Configuration word written |
| poke_en | input | 1 | Poke strobe |
| poke_idx | input | IDX_W | Watchdog selected by the poke |
| rd_idx | input | IDX_W | Watchdog selected for readback |
| rd_data | output | 64 | Word of the selected watchdog |
| dbg_stop | input | 1 | Debug halt indication |
| glb_stop | input | 1 | Global halt indication |
| irq_first | output | N_WDT | One-cycle pulse per watchdog on entering stage 1 |
| irq_second | output | N_WDT | One-cycle pulse per watchdog on entering stage 2 |
| rst_req | output | N_WDT | Sticky reset request per watchdog |

## Verification
The assertions cover the per-cycle rules. Interrupts last one cycle and never coincide. Reset requests are sticky. The stage never passes the mode, and each pulse matches the stage just entered. Pokes, zero writes and a held halt suppress any expiry or count change in the following cycle. The exact spacing of expiries, the range in which the first expiry of a period can fall, the decrement rate, the mode caps, the effect of sustained poking and the out-of-range index handling are observed only in the bench's directed scenarios. These scenarios use small parameter values so that full periods fit in a short run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef logic [1:0] mode_t;

  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_FIRST  = 2'd1,
    STG_SECOND = 2'd2,
    STG_RESET  = 2'd3
  } stage_t;

  localparam int WORD_W = 64;
  localparam int MODE_LSB = 0;
  localparam int STAGE_LSB = 2;
  localparam int LEN_LSB = 4;

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int TICK_LOG2 = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  logic [TICK_LOG2-1:0] div_q;
  logic [TICK_LOG2-1:0] div_d;

  assign div_d  = div_q + TICK_LOG2'(1);
  assign tick_o = &div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/wdog_channel.sv
module wdog_channel
  import wdog_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_we,
  input  mode_t            cfg_mode,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_dstop,
  input  logic             cfg_gstop,
  input  logic             poke,
  input  logic             dbg_stop,
  input  logic             glb_stop,
  output mode_t            mode_o,
  output stage_t           stage_o,
  output logic [LEN_W-1:0] len_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dstop_o,
  output logic             gstop_o,
  output logic             irq1_o,
  output logic             irq2_o,
  output logic             rst_req_o
);

  localparam int SHIFT = CNT_W - LEN_W;

  mode_t            mode_q;
  logic [LEN_W-1:0] len_q;
  logic             dstop_q;
  logic             gstop_q;

  stage_t           stage_q, stage_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq1_q, irq1_d;
  logic             irq2_q, irq2_d;
  logic             rreq_q, rreq_d;

  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] wr_load_val;
  logic             capped;
  logic             frozen;
  logic             step;
  logic             last;

  assign reload_val  = CNT_W'(len_q) << SHIFT;
  assign wr_load_val = CNT_W'(cfg_len) << SHIFT;
  assign capped      = (2'(stage_q) >= mode_q);
  assign frozen      = (dstop_q & dbg_stop) | (gstop_q & glb_stop);
  assign step        = tick & ~capped & ~frozen;
  assign last        = (cnt_q <= CNT_W'(1));

  // configuration fields: written only on cfg_we
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      len_q   <= '0;
      dstop_q <= 1'b0;
      gstop_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= cfg_mode;
      len_q   <= cfg_len;
      dstop_q <= cfg_dstop;
      gstop_q <= cfg_gstop;
    end
  end

  // next-state for count, stage and outputs
  always_comb begin
    stage_d = stage_q;
    cnt_d   = cnt_q;
    irq1_d  = 1'b0;
    irq2_d  = 1'b0;
    rreq_d  = rreq_q;
    if (cfg_we) begin
      stage_d = STG_IDLE;
      cnt_d   = wr_load_val;
    end else if (poke) begin
      stage_d = STG_IDLE;
      cnt_d   = reload_val;
    end else if (step) begin
      if (last) begin
        cnt_d = reload_val;
        case (stage_q)
          STG_IDLE: begin
            stage_d = STG_FIRST;
            irq1_d  = 1'b1;
          end
          STG_FIRST: begin
            stage_d = STG_SECOND;
            irq2_d  = 1'b1;
          end
          STG_SECOND: begin
            stage_d = STG_RESET;
            rreq_d  = 1'b1;
          end
          default: stage_d = stage_q;
        endcase
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= STG_IDLE;
      cnt_q   <= '0;
      irq1_q  <= 1'b0;
      irq2_q  <= 1'b0;
      rreq_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      cnt_q   <= cnt_d;
      irq1_q  <= irq1_d;
      irq2_q  <= irq2_d;
      rreq_q  <= rreq_d;
    end
  end

  assign mode_o    = mode_q;
  assign stage_o   = stage_q;
  assign len_o     = len_q;
  assign cnt_o     = cnt_q;
  assign dstop_o   = dstop_q;
  assign gstop_o   = gstop_q;
  assign irq1_o    = irq1_q;
  assign irq2_o    = irq2_q;
  assign rst_req_o = rreq_q;

endmodule

// File: rtl/wdog_bank.sv
module wdog_bank
  import wdog_pkg::*;
#(
  parameter int N_WDT     = 4,
  parameter int LEN_W     = 16,
  parameter int CNT_W     = 24,
  parameter int TICK_LOG2 = 10,
  localparam int IDX_W    = (N_WDT > 1) ? $clog2(N_WDT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [63:0]       wr_data,
  input  logic              poke_en,
  input  logic [IDX_W-1:0]  poke_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [63:0]       rd_data,
  input  logic              dbg_stop,
  input  logic              glb_stop,
  output logic [N_WDT-1:0]  irq_first,
  output logic [N_WDT-1:0]  irq_second,
  output logic [N_WDT-1:0]  rst_req
);

  localparam int CNT_LSB   = LEN_LSB + LEN_W;
  localparam int DSTOP_BIT = CNT_LSB + CNT_W;
  localparam int GSTOP_BIT = DSTOP_BIT + 1;
  localparam int PAD_W     = WORD_W - GSTOP_BIT - 1;

  initial begin
    if (PAD_W < 1 || LEN_W > CNT_W || TICK_LOG2 < 1) begin
      $error("wdog_bank: parameter combination not supported");
    end
  end

  logic tick;

  wdog_tick_gen #(.TICK_LOG2(TICK_LOG2)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  // write-field extraction
  mode_t            wr_mode;
  logic [LEN_W-1:0] wr_len;
  logic             wr_dstop;
  logic             wr_gstop;
  logic             unused_wr_bits;

  assign wr_mode  = wr_data[MODE_LSB +: 2];
  assign wr_len   = wr_data[LEN_LSB +: LEN_W];
  assign wr_dstop = wr_data[DSTOP_BIT];
  assign wr_gstop = wr_data[GSTOP_BIT];
  assign unused_wr_bits = ^{wr_data[STAGE_LSB +: 2], wr_data[CNT_LSB +: CNT_W],
                            wr_data[WORD_W-1:GSTOP_BIT+1]};

  logic [WORD_W-1:0] stat_w [N_WDT];

  for (genvar g = 0; g < N_WDT; g++) begin : g_wdt
    logic             wr_hit;
    logic             poke_hit;
    mode_t            ch_mode;
    stage_t           ch_stage;
    logic [LEN_W-1:0] ch_len;
    logic [CNT_W-1:0] ch_cnt;
    logic             ch_dstop;
    logic             ch_gstop;

    assign wr_hit   = wr_en   && (wr_idx   == IDX_W'(g));
    assign poke_hit = poke_en && (poke_idx == IDX_W'(g));

    wdog_channel #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .cfg_we    (wr_hit),
      .cfg_mode  (wr_mode),
      .cfg_len   (wr_len),
      .cfg_dstop (wr_dstop),
      .cfg_gstop (wr_gstop),
      .poke      (poke_hit),
      .dbg_stop  (dbg_stop),
      .glb_stop  (glb_stop),
      .mode_o    (ch_mode),
      .stage_o   (ch_stage),
      .len_o     (ch_len),
      .cnt_o     (ch_cnt),
      .dstop_o   (ch_dstop),
      .gstop_o   (ch_gstop),
      .irq1_o    (irq_first[g]),
      .irq2_o    (irq_second[g]),
      .rst_req_o (rst_req[g])
    );

    assign stat_w[g] = {{PAD_W{1'b0}}, ch_gstop, ch_dstop, ch_cnt, ch_len,
                        2'(ch_stage), ch_mode};
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < N_WDT; k++) begin
      if (rd_idx == IDX_W'(k)) begin
        rd_data = stat_w[k];
      end
    end
  end

endmodule

// File: rtl/wdog_bank_chk.sv
module wdog_bank_chk #(
  parameter int N_WDT = 4,
  parameter int LEN_W = 16,
  parameter int CNT_W = 24,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [63:0]      wr_data,
  input logic             poke_en,
  input logic [IDX_W-1:0] poke_idx,
  input logic             dbg_stop,
  input logic             glb_stop,
  input logic [N_WDT-1:0] irq_first,
  input logic [N_WDT-1:0] irq_second,
  input logic [N_WDT-1:0] rst_req,
  input logic [63:0]      stat_w [N_WDT]
);

  localparam int CNT_LSB   = 4 + LEN_W;
  localparam int DSTOP_BIT = CNT_LSB + CNT_W;
  localparam int GSTOP_BIT = DSTOP_BIT + 1;

  for (genvar g = 0; g < N_WDT; g++) begin : g_chk
    logic wr_hit, poke_hit, frozen;
    logic [1:0] mode_f, stage_f;
    assign wr_hit   = wr_en && (wr_idx == IDX_W'(g));
    assign poke_hit = poke_en && (poke_idx == IDX_W'(g));
    assign mode_f   = stat_w[g][1:0];
    assign stage_f  = stat_w[g][3:2];
    assign frozen   = (stat_w[g][DSTOP_BIT] & dbg_stop) | (stat_w[g][GSTOP_BIT] & glb_stop);

    // R5
    irq1_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_first[g] |=> !irq_first[g]);
    // R5
    irq2_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_second[g] |=> !irq_second[g]);
    // R5
    irq_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_first[g] && irq_second[g]));
    // R5
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req[g] |=> rst_req[g]);
    // R4
    irq1_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_first[g] |-> (stage_f == 2'd1));
    // R6
    stage_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_f <= mode_f);
    // R7
    poke_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poke_hit && !wr_hit) |=> (!irq_first[g] && !irq_second[g] && stage_f == 2'd0));
    // R9
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_data == 64'd0) |=> (stat_w[g] == 64'd0 && !irq_first[g]));
    // R8
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !wr_hit && !poke_hit) |=> $stable(stat_w[g][CNT_LSB +: CNT_W]));
  end

endmodule

bind wdog_bank wdog_bank_chk #(
  .N_WDT (N_WDT),
  .LEN_W (LEN_W),
  .CNT_W (CNT_W),
  .IDX_W (IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .poke_en    (poke_en),
  .poke_idx   (poke_idx),
  .dbg_stop   (dbg_stop),
  .glb_stop   (glb_stop),
  .irq_first  (irq_first),
  .irq_second (irq_second),
  .rst_req    (rst_req),
  .stat_w     (stat_w)
);

// File: tb/wdog_bank_bench.sv
module wdog_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;
  localparam int LW = 4;
  localparam int CW = 6;
  localparam int TL = 2;
  localparam int IW = 2;
  localparam int PER1 = 16;  // clocks per unit of length: 2^(CW-LW+TL)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, poke_en = 1'b0, dbg_stop = 1'b0, glb_stop = 1'b0;
  logic [IW-1:0] wr_idx = '0, poke_idx = '0, rd_idx = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic [N-1:0] irq_first, irq_second, rst_req;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  int n1 [N];
  int n2 [N];
  int t1 [N];
  int t2 [N];
  int t3 [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_bank #(.N_WDT(N), .LEN_W(LW), .CNT_W(CW), .TICK_LOG2(TL)) u_wdog_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .poke_en(poke_en), .poke_idx(poke_idx), .rd_idx(rd_idx), .rd_data(rd_data),
    .dbg_stop(dbg_stop), .glb_stop(glb_stop), .irq_first(irq_first),
    .irq_second(irq_second), .rst_req(rst_req));

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int c = 0; c < N; c++) begin
      n1[c] = 0; n2[c] = 0; t1[c] = -1; t2[c] = -1; t3[c] = -1;
    end
  end

  always @(negedge clk) begin
    for (int c = 0; c < N; c++) begin
      if (irq_first[c])  begin n1[c] = n1[c] + 1; t1[c] = cyc; end
      if (irq_second[c]) begin n2[c] = n2[c] + 1; t2[c] = cyc; end
      if (rst_req[c] && t3[c] < 0) t3[c] = cyc;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // word: mode[1:0] stage[3:2] len[7:4] cnt[13:8] dstop[14] gstop[15]
  function automatic logic [63:0] cfg(input int mode, input int len, input bit ds, input bit gs);
    return 64'(mode) | (64'(len) << 4) | (64'(ds) << 14) | (64'(gs) << 15);
  endfunction

  task automatic wr(input int idx, input logic [63:0] d, output int wcyc);
    @(negedge clk); wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk); wr_en = 1'b0; wcyc = cyc;
  endtask

  task automatic poke(input int idx);
    @(negedge clk); poke_en = 1'b1; poke_idx = IW'(idx);
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [63:0] d);
    rd_idx = IW'(idx); #1; d = rd_data;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    for (int c = 0; c < N; c++) begin rd(c, d); chk("R1 word zero", d, 0); end
    chk("R1 irq_first low", irq_first, 0);
    chk("R1 irq_second low", irq_second, 0);
    chk("R1 rst_req low", rst_req, 0);
  endtask

  task automatic t_escalate();
    int w, a1, a2; logic [63:0] d;
    a1 = n1[0]; a2 = n2[0];
    wr(0, cfg(3, 2, 0, 0), w);
    wait_clk(110);
    chk("R5 one first irq", n1[0] - a1, 1);
    chk("R5 one second irq", n2[0] - a2, 1);
    chk_rng("R4 first expiry window", t1[0] - w, 2*PER1 - 3, 2*PER1);
    chk("R4 second expiry spacing", t2[0] - t1[0], 2*PER1);
    chk("R5 reset request spacing", t3[0] - t1[0], 4*PER1);
    rd(0, d); chk("R6 stage 3 reached", d[3:2], 3);
    wait_clk(60);
    chk("R5 reset request sticky", rst_req[0], 1);
    chk("R6 no more irq after cap", n1[0] - a1, 1);
  endtask

  task automatic t_mode_caps();
    int w, a1, a2, b1, b2; logic [63:0] d;
    a1 = n1[1]; a2 = n2[1]; b1 = n1[2]; b2 = n2[2];
    wr(1, cfg(1, 1, 0, 0), w);
    wr(2, cfg(2, 1, 0, 0), w);
    wait_clk(80);
    chk("R6 mode1 first irq", n1[1] - a1, 1);
    chk("R6 mode1 no second irq", n2[1] - a2, 0);
    rd(1, d); chk("R6 mode1 stage", d[3:2], 1);
    chk("R4 mode1 reloaded count", d[13:8], 4);
    wait_clk(20);
    rd(1, d); chk("R6 mode1 count held", d[13:8], 4);
    chk("R6 mode2 first irq", n1[2] - b1, 1);
    chk("R6 mode2 second irq", n2[2] - b2, 1);
    rd(2, d); chk("R6 mode2 stage", d[3:2], 2);
    chk("R6 mode2 no reset", rst_req[2], 0);
  endtask

  task automatic t_poke();
    int w, a1; logic [63:0] d;
    a1 = n1[1];
    wr(1, cfg(3, 2, 0, 0), w);
    repeat (10) begin wait_clk(20); poke(1); end
    chk("R7 pokes prevent expiry", n1[1] - a1, 0);
    rd(1, d); chk("R7 stage idle", d[3:2], 0);
    wait_clk(40);
    chk("R7 expiry after pokes stop", n1[1] - a1, 1);
    chk("R10 other reset untouched", rst_req[1], 0);
  endtask

  task automatic t_count_and_write();
    int w; logic [63:0] d;
    wr(1, cfg(1, 3, 0, 0) | (64'hF << 2) | (64'h3F << 8), w);
    rd(1, d); chk("R2 write ignores stage/count bits", d, cfg(1, 3, 0, 0) | (64'd12 << 8));
    wait_clk(40);
    rd(1, d); chk("R3 ten ticks in 40 clocks", d[13:8], 2);
  endtask

  task automatic t_stop();
    int w, a1; logic [63:0] d;
    a1 = n1[1];
    @(negedge clk); dbg_stop = 1'b1;
    wr(1, cfg(1, 3, 1, 0), w);
    wait_clk(60);
    rd(1, d); chk("R8 debug stop freezes count", d[13:8], 12);
    chk("R8 no expiry while frozen", n1[1] - a1, 0);
    dbg_stop = 1'b0; glb_stop = 1'b1;
    wait_clk(40);
    rd(1, d); chk("R8 unenabled global stop ignored", d[13:8], 2);
    glb_stop = 1'b0;
  endtask

  task automatic t_len_zero();
    int w, a1;
    a1 = n1[2];
    wr(2, cfg(1, 0, 0, 0), w);
    wait_clk(5);
    chk("R4 length zero expires on first tick", n1[2] - a1, 1);
    chk_rng("R4 length zero timing", t1[2] - w, 1, 4);
  endtask

  task automatic t_disable();
    int w, a1, a2; logic [63:0] d;
    a1 = n1[2]; a2 = n2[2];
    wr(2, 64'd0, w);
    rd(2, d); chk("R9 zero write reads zero", d, 0);
    poke(2);
    wait_clk(100);
    rd(2, d); chk("R9 disabled stays zero", d, 0);
    chk("R9 disabled no irq", (n1[2] - a1) + (n2[2] - a2), 0);
  endtask

  task automatic t_range();
    int w; logic [63:0] d0, d1, e0, e1;
    rd(0, d0); rd(1, d1);
    wr(3, cfg(3, 5, 1, 1), w);
    poke(3);
    rd(0, e0); rd(1, e1);
    chk("R10 out-of-range write ch0", e0, d0);
    chk("R10 out-of-range write ch1 stage", e1[3:0], d1[3:0]);
    rd(3, e0); chk("R10 out-of-range read zero", e0, 0);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    t_reset();
    t_escalate();
    t_mode_caps();
    t_poke();
    t_count_and_write();
    t_stop();
    t_len_zero();
    t_disable();
    t_range();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule